// File: doc/BRIEF.md
# Output Event FIFO with Programmable Thresholds

This block is the output side of a waveform capture channel. A capture engine pushes header and sample words into a 4096 x 31-bit store. A host reads them back as 32-bit words over a simple 16-bit register bus. Each word it returns carries a header/data marker and a flag that tells whether more words remain. Two programmable thresholds drive active-low status bits. The almost-empty bit tells the host that a known amount of data is waiting. The almost-full bit stops the capture engine, through the busy output, before an event can be split.

The same bus loads a 12-bit circular-buffer length, which goes out to the capture engine unchanged. It also holds a sample-count register, the mode bits and a software stop bit, and it shows two event counters supplied from outside. The thresholds and the length go in through one staging register in four commits. An internal 2-bit step counter decides which piece each commit loads. Any access to the reset offset returns the whole block to its power-on state.

Top module: `ofifo_top`

## Requirements
- R1: After rst_n low, or after any access at offset 0x10, the FIFO is empty, mode bits are 2'b11, the sample register is 1024, both thresholds, the length output and the step counter are 0, and sw_stop is 0.
- R2: Any access (read or write) at offset 0x0E commits the staged setting according to a 2-bit step counter, which then advances modulo 4. Step 0 loads ae_thr[7:0] from stage[15:8]. Step 1 loads ae_thr[11:8] from stage[11:8]. Step 2 loads af_thr[7:0] from stage[15:8] and cbl[7:0] from stage[7:0]. Step 3 loads af_thr[11:8] from stage[11:8] and cbl[11:8] from stage[3:0].
- R3: A write to the setting register at 0x0C only fills the stage. Thresholds and cbl stay unchanged until the next commit at 0x0E.
- R4: Pushed words come out in push order. Reading offset 0x00 returns {hdr, more, payload[29:0]} and removes one word.
- R5: Bit 30 (more) of a returned data word is 1 exactly when the FIFO still holds a word after this read.
- R6: Reading 0x00 while the FIFO is empty returns 32'h0 and leaves the FIFO contents and order untouched.
- R7: A push while 4096 words are stored is dropped. The store never holds more than 4096 words.
- R8: Status bit 2 at 0x0A (ae_n) is 1 exactly when the stored count is at least ae_thr+1.
- R9: Status bit 3 at 0x0A (af_n) is 1 exactly when the free space (4096 minus count) is at least af_thr+1. Bit 4 is 1 when the FIFO is non-empty.
- R10: Writing 0x0A sets the mode bits from wdata[1:0], which read back on bits 1:0. acq_mode is 1 only for mode 2'b00. busy is 1 whenever acq_mode is 0 or af_n is 0.
- R11: Offset 0x04 reads and writes a 12-bit sample count, exported on samples, with upper write bits ignored. Offsets 0x06 and 0x08 read acc_count and rej_count. Offset 0x12 holds sw_stop in bit 0. Register reads are zero-extended to 32 bits.
- R12: A read access and a write access at 0x10 both perform the reset of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid from the edge that takes the access |
| push_valid | input | 1 | Capture engine pushes one word |
| push_hdr | input | 1 | Pushed word is a header |
| push_data | input | 30 | Time tag or three 10-bit samples |
| acc_count | input | 12 | Accepted-event counter shown at 0x06 |
| rej_count | input | 12 | Rejected-event counter shown at 0x08 |
| cbl | output | 12 | Circular-buffer length for the capture engine |
| samples | output | 12 | Samples per event |
| acq_mode | output | 1 | Acquisition mode active |
| busy | output | 1 | Capture must not start an event |
| sw_stop | output | 1 | Software stop level |

## Verification
The assertions assume that bus_sel lasts one cycle for each access. They also assume that the capture engine does not push in the same cycle as a reset access. The bench drives every access and every push as a single-cycle pulse set up on the falling edge, and it never overlaps a push with a bus access at 0x10. Counts and threshold crossings are predicted from a simple count model in the bench. The full case overfills by four pushes, so the dropped words must be absent from the read-back sequence.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;
  localparam int BUS_AW = 5;

  localparam logic [BUS_AW-1:0] OFS_DATA = 5'h00;
  localparam logic [BUS_AW-1:0] OFS_SAMP = 5'h04;
  localparam logic [BUS_AW-1:0] OFS_ACC  = 5'h06;
  localparam logic [BUS_AW-1:0] OFS_REJ  = 5'h08;
  localparam logic [BUS_AW-1:0] OFS_CSR  = 5'h0A;
  localparam logic [BUS_AW-1:0] OFS_SET  = 5'h0C;
  localparam logic [BUS_AW-1:0] OFS_UPD  = 5'h0E;
  localparam logic [BUS_AW-1:0] OFS_RST  = 5'h10;
  localparam logic [BUS_AW-1:0] OFS_STOP = 5'h12;

  localparam logic [1:0] MODE_ACQ  = 2'b00;
  localparam logic [1:0] MODE_PROG = 2'b11;

  typedef enum logic [1:0] {
    STEP_AE_LO = 2'd0,
    STEP_AE_HI = 2'd1,
    STEP_AF_LO = 2'd2,
    STEP_AF_HI = 2'd3
  } step_e;
endpackage

// File: rtl/ofifo_regs.sv
module ofifo_regs
  import ofifo_pkg::*;
#(
  parameter int THR_W      = 12,
  parameter int SAMP_W     = 12,
  parameter int BUS_DW     = 16,
  parameter int SAMP_RESET = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              soft_clr,
  output logic              pop_req,
  output logic [THR_W-1:0]  ae_thr,
  output logic [THR_W-1:0]  af_thr,
  output logic [THR_W-1:0]  cbl,
  output logic [SAMP_W-1:0] samples,
  output logic [1:0]        mode,
  output logic              sw_stop,
  output logic [1:0]        step
);
  localparam int LO_W = 8;
  localparam int HI_W = THR_W - LO_W;
  localparam logic [SAMP_W-1:0] SAMP_INIT = SAMP_W'(SAMP_RESET);

  logic [BUS_DW-1:0] stage_q, stage_n;
  logic [THR_W-1:0]  ae_q, ae_n, af_q, af_n, cbl_q, cbl_n;
  logic [SAMP_W-1:0] samp_q, samp_n;
  logic [1:0]        mode_q, mode_n;
  logic              stop_q, stop_n;
  step_e             step_q, step_n;
  logic              wr_hit, upd_hit;

  assign soft_clr = bus_sel && (bus_addr == OFS_RST);
  assign pop_req  = bus_sel && !bus_wr && (bus_addr == OFS_DATA);
  assign wr_hit   = bus_sel && bus_wr;
  assign upd_hit  = bus_sel && (bus_addr == OFS_UPD);

  always_comb begin
    stage_n = stage_q;
    ae_n    = ae_q;
    af_n    = af_q;
    cbl_n   = cbl_q;
    samp_n  = samp_q;
    mode_n  = mode_q;
    stop_n  = stop_q;
    step_n  = step_q;
    if (wr_hit && bus_addr == OFS_SET)  stage_n = bus_wdata;
    if (wr_hit && bus_addr == OFS_SAMP) samp_n  = bus_wdata[SAMP_W-1:0];
    if (wr_hit && bus_addr == OFS_CSR)  mode_n  = bus_wdata[1:0];
    if (wr_hit && bus_addr == OFS_STOP) stop_n  = bus_wdata[0];
    if (upd_hit) begin
      step_n = step_e'(step_q + 2'd1);
      case (step_q)
        STEP_AE_LO: ae_n[LO_W-1:0] = stage_q[BUS_DW-1 -: LO_W];
        STEP_AE_HI: ae_n[THR_W-1:LO_W] = stage_q[LO_W +: HI_W];
        STEP_AF_LO: begin
          af_n[LO_W-1:0]  = stage_q[BUS_DW-1 -: LO_W];
          cbl_n[LO_W-1:0] = stage_q[LO_W-1:0];
        end
        default: begin
          af_n[THR_W-1:LO_W]  = stage_q[LO_W +: HI_W];
          cbl_n[THR_W-1:LO_W] = stage_q[HI_W-1:0];
        end
      endcase
    end
    if (soft_clr) begin
      stage_n = '0;
      ae_n    = '0;
      af_n    = '0;
      cbl_n   = '0;
      samp_n  = SAMP_INIT;
      mode_n  = MODE_PROG;
      stop_n  = 1'b0;
      step_n  = STEP_AE_LO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      ae_q    <= '0;
      af_q    <= '0;
      cbl_q   <= '0;
      samp_q  <= SAMP_INIT;
      mode_q  <= MODE_PROG;
      stop_q  <= 1'b0;
      step_q  <= STEP_AE_LO;
    end else begin
      stage_q <= stage_n;
      ae_q    <= ae_n;
      af_q    <= af_n;
      cbl_q   <= cbl_n;
      samp_q  <= samp_n;
      mode_q  <= mode_n;
      stop_q  <= stop_n;
      step_q  <= step_n;
    end
  end

  assign ae_thr  = ae_q;
  assign af_thr  = af_q;
  assign cbl     = cbl_q;
  assign samples = samp_q;
  assign mode    = mode_q;
  assign sw_stop = stop_q;
  assign step    = step_q;
endmodule

// File: rtl/ofifo_store.sv
module ofifo_store #(
  parameter int AW    = 12,
  parameter int WORD_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic [AW:0]       count
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [AW:0]   cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign push_ok = push && (cnt_q != FULL_CNT);
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push_ok) wr_n = wr_q + 1'b1;
    if (pop_ok)  rd_n = rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= push_word;
  end

  assign head_word = mem[rd_q];
  assign count     = cnt_q;
endmodule

// File: rtl/ofifo_flags.sv
module ofifo_flags #(
  parameter int AW    = 12,
  parameter int THR_W = 12
) (
  input  logic [AW:0]      count,
  input  logic [THR_W-1:0] ae_thr,
  input  logic [THR_W-1:0] af_thr,
  output logic             ae_n,
  output logic             af_n,
  output logic             nempty,
  output logic             more_after
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0] free_cnt;

  always_comb begin
    free_cnt   = FULL_CNT - count;
    ae_n       = count > (AW+1)'(ae_thr);
    af_n       = free_cnt > (AW+1)'(af_thr);
    nempty     = count != '0;
    more_after = count > (AW+1)'(1);
  end
endmodule

// File: rtl/ofifo_top.sv
module ofifo_top
  import ofifo_pkg::*;
#(
  parameter int FIFO_AW    = 12,
  parameter int THR_W      = 12,
  parameter int SAMP_W     = 12,
  parameter int EVT_W      = 12,
  parameter int BUS_DW     = 16,
  parameter int RD_W       = 32,
  parameter int PAY_W      = 30,
  parameter int SAMP_RESET = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  input  logic              push_valid,
  input  logic              push_hdr,
  input  logic [PAY_W-1:0]  push_data,
  input  logic [EVT_W-1:0]  acc_count,
  input  logic [EVT_W-1:0]  rej_count,
  output logic [THR_W-1:0]  cbl,
  output logic [SAMP_W-1:0] samples,
  output logic              acq_mode,
  output logic              busy,
  output logic              sw_stop
);
  localparam int DEPTH  = 1 << FIFO_AW;
  localparam int WORD_W = PAY_W + 1;

  logic              soft_clr, pop_req;
  logic [THR_W-1:0]  ae_thr, af_thr;
  logic [1:0]        mode, step;
  logic [WORD_W-1:0] head_word;
  logic [FIFO_AW:0]  count;
  logic              ae_n, af_n, nempty, more_after;
  logic [RD_W-1:0]   rdata_q, rdata_n;

  ofifo_regs #(
    .THR_W(THR_W), .SAMP_W(SAMP_W), .BUS_DW(BUS_DW), .SAMP_RESET(SAMP_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .soft_clr(soft_clr),
    .pop_req(pop_req), .ae_thr(ae_thr), .af_thr(af_thr), .cbl(cbl),
    .samples(samples), .mode(mode), .sw_stop(sw_stop), .step(step)
  );

  ofifo_store #(.AW(FIFO_AW), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .push(push_valid),
    .push_word({push_hdr, push_data}), .pop(pop_req),
    .head_word(head_word), .count(count)
  );

  ofifo_flags #(.AW(FIFO_AW), .THR_W(THR_W)) u_flags (
    .count(count), .ae_thr(ae_thr), .af_thr(af_thr), .ae_n(ae_n),
    .af_n(af_n), .nempty(nempty), .more_after(more_after)
  );

  always_comb begin
    rdata_n = rdata_q;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_DATA: rdata_n = nempty ? {head_word[WORD_W-1], more_after, head_word[PAY_W-1:0]} : '0;
        OFS_SAMP: rdata_n = RD_W'(samples);
        OFS_ACC:  rdata_n = RD_W'(acc_count);
        OFS_REJ:  rdata_n = RD_W'(rej_count);
        OFS_CSR:  rdata_n = RD_W'({nempty, af_n, ae_n, mode});
        OFS_STOP: rdata_n = RD_W'(sw_stop);
        default:  rdata_n = '0;
      endcase
    end
    if (soft_clr) rdata_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;
  assign acq_mode  = (mode == MODE_ACQ);
  assign busy      = !acq_mode || !af_n;
endmodule

// File: rtl/ofifo_chk.sv
module ofifo_chk
  import ofifo_pkg::*;
#(
  parameter int AW         = 12,
  parameter int THR_W      = 12,
  parameter int SAMP_W     = 12,
  parameter int RD_W       = 32,
  parameter int SAMP_RESET = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [RD_W-1:0]   bus_rdata,
  input logic              push_valid,
  input logic [AW:0]       count,
  input logic [1:0]        step,
  input logic              af_n,
  input logic              busy,
  input logic              acq_mode,
  input logic [1:0]        mode,
  input logic [THR_W-1:0]  cbl,
  input logic [SAMP_W-1:0] samples
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(1 << AW);
  localparam logic [SAMP_W-1:0] SAMP_INIT = SAMP_W'(SAMP_RESET);

  logic data_rd, upd_acc, rst_acc;
  assign data_rd = bus_sel && !bus_wr && bus_addr == OFS_DATA;
  assign upd_acc = bus_sel && bus_addr == OFS_UPD;
  assign rst_acc = bus_sel && bus_addr == OFS_RST;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_acc |=> (count == '0 && mode == MODE_PROG && samples == SAMP_INIT && cbl == '0 && step == 2'd0));

  assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_acc |=> step == $past(step) + 2'd1);

  assert_cbl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_acc || rst_acc) |=> $stable(cbl));

  assert_more_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && count > (AW+1)'(1)) |=> bus_rdata[30]);

  assert_more_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && count == (AW+1)'(1)) |=> !bus_rdata[30]);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && count == '0 && !push_valid) |=> (bus_rdata == '0 && count == '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  assert_busy_on_af_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !af_n |-> busy);

  assert_busy_outside_acq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_mode |-> busy);
endmodule

bind ofifo_top ofifo_chk #(
  .AW(FIFO_AW), .THR_W(THR_W), .SAMP_W(SAMP_W), .RD_W(RD_W), .SAMP_RESET(SAMP_RESET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .push_valid(push_valid),
  .count(count), .step(step), .af_n(af_n), .busy(busy),
  .acq_mode(acq_mode), .mode(mode), .cbl(cbl), .samples(samples)
);

// File: tb/sim_ofifo_top.sv
module sim_ofifo_top;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        push_valid, push_hdr;
  logic [29:0] push_data;
  logic [11:0] acc_count, rej_count;
  logic [11:0] cbl, samples;
  logic        acq_mode, busy, sw_stop;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ofifo_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .push_valid(push_valid), .push_hdr(push_hdr), .push_data(push_data),
    .acc_count(acc_count), .rej_count(rej_count), .cbl(cbl),
    .samples(samples), .acq_mode(acq_mode), .busy(busy), .sw_stop(sw_stop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [4:0] a, input logic [15:0] d, output logic [31:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    r = bus_rdata;
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, r);
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] r);
    bus(1'b0, a, 16'h0, r);
  endtask

  task automatic push(input logic h, input logic [29:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_hdr = h; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // status word: {nonempty, af_n, ae_n, mode}
  function automatic logic [31:0] csr_exp(int cnt, int ae, int af, logic [1:0] m);
    return {27'b0, cnt > 0, (DEPTH - cnt) >= af + 1, cnt >= ae + 1, m};
  endfunction

  task automatic t_reset_state;
    logic [31:0] r;
    chk("R1 cbl", 32'(cbl), 32'h0);
    chk("R1 busy", 32'(busy), 32'h1);
    chk("R1 sw_stop", 32'(sw_stop), 32'h0);
    rd32(5'h0A, r); chk("R1 status", r, csr_exp(0, 0, 0, 2'b11));
    rd32(5'h04, r); chk("R1 samples", r, 32'd1024);
  endtask

  task automatic t_program;
    logic [31:0] r;
    wr16(5'h0C, 16'h0400);                 // ae lo = 0x04
    wr16(5'h0E, 16'h0);
    wr16(5'h0C, 16'hF000);                 // ae hi = 0 (bits 15:12 ignored)
    rd32(5'h0E, r);                        // update by read access
    wr16(5'h0C, 16'hFABC);                 // af lo = 0xFA, cbl lo = 0xBC
    chk("R3 cbl before commit", 32'(cbl), 32'h0);
    wr16(5'h0E, 16'h0);
    chk("R2 cbl low piece", 32'(cbl), 32'h0BC);
    wr16(5'h0C, 16'h0F0A);                 // af hi = 0xF, cbl hi = 0xA
    wr16(5'h0E, 16'h0);
    chk("R2 cbl full", 32'(cbl), 32'hABC);
    wr16(5'h0C, 16'h1234);
    chk("R3 stage only", 32'(cbl), 32'hABC);
    wr16(5'h0C, 16'h0500);                 // step wrapped to 0: ae lo = 5
    wr16(5'h0E, 16'h0);
    chk("R2 wrap keeps cbl", 32'(cbl), 32'hABC);
    wr16(5'h0A, 16'h0000);
    chk("R10 acq_mode", 32'(acq_mode), 32'h1);
    chk("R10 busy clear", 32'(busy), 32'h0);
    rd32(5'h0A, r); chk("R10 mode readback", r, csr_exp(0, 5, 4090, 2'b00));
  endtask

  // ae_thr=5, af_thr=4090
  task automatic t_flags_and_order;
    logic [31:0] r;
    logic [29:0] pay [6];
    logic        hd  [6];
    pay[0] = 30'h1234567;  hd[0] = 1'b1;
    pay[1] = 30'h0ABCDEF;  hd[1] = 1'b0;
    pay[2] = 30'h3FFFFFFF; hd[2] = 1'b0;
    pay[3] = 30'h0000001;  hd[3] = 1'b0;
    pay[4] = 30'h2AAAAAAA; hd[4] = 1'b1;
    pay[5] = 30'h1555555;  hd[5] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      push(hd[i], pay[i]);
      rd32(5'h0A, r);
      chk($sformatf("R8 R9 status at count %0d", i + 1), r, csr_exp(i + 1, 5, 4090, 2'b00));
      chk($sformatf("R10 busy at count %0d", i + 1), 32'(busy), 32'(i + 1 > 5));
    end
    for (int i = 0; i < 6; i++) begin
      rd32(5'h00, r);
      chk($sformatf("R4 R5 word %0d", i), r, {hd[i], i < 5, pay[i]});
    end
  endtask

  task automatic t_empty_read;
    logic [31:0] r;
    rd32(5'h00, r); chk("R6 empty word", r, 32'h0);
    rd32(5'h0A, r); chk("R6 still empty", r, csr_exp(0, 5, 4090, 2'b00));
    push(1'b1, 30'h0F0F0F0);
    rd32(5'h00, r); chk("R6 order kept", r, {1'b1, 1'b0, 30'h0F0F0F0});
  endtask

  task automatic t_full;
    logic [31:0] r;
    for (int i = 0; i < DEPTH + 4; i++) push(1'b0, 30'(i));
    rd32(5'h0A, r); chk("R7 R9 full status", r, csr_exp(DEPTH, 5, 4090, 2'b00));
    chk("R10 busy when full", 32'(busy), 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      rd32(5'h00, r);
      chk("R7 drain", r, {1'b0, i < DEPTH - 1, 30'(i)});
    end
    rd32(5'h00, r); chk("R7 extra pushes dropped", r, 32'h0);
  endtask

  task automatic t_misc_regs;
    logic [31:0] r;
    wr16(5'h04, 16'hF123);
    rd32(5'h04, r); chk("R11 samples 12 bit", r, 32'h123);
    chk("R11 samples port", 32'(samples), 32'h123);
    rd32(5'h06, r); chk("R11 accepted", r, 32'hABC);
    rd32(5'h08, r); chk("R11 rejected", r, 32'h5A5);
    wr16(5'h12, 16'h0001);
    chk("R11 sw_stop set", 32'(sw_stop), 32'h1);
    rd32(5'h12, r); chk("R11 stop readback", r, 32'h1);
    wr16(5'h12, 16'h0000);
    chk("R11 sw_stop clear", 32'(sw_stop), 32'h0);
    rd32(5'h0C, r); chk("R11 setting reads zero", r, 32'h0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] r;
    push(1'b1, 30'h11);
    push(1'b0, 30'h22);
    wr16(5'h12, 16'h0001);
    rd32(5'h10, r);                        // reset by read access
    chk("R12 read reset mode", 32'(acq_mode), 32'h0);
    chk("R1 cbl cleared", 32'(cbl), 32'h0);
    chk("R1 sw_stop cleared", 32'(sw_stop), 32'h0);
    rd32(5'h0A, r); chk("R1 status after reset", r, csr_exp(0, 0, 0, 2'b11));
    rd32(5'h04, r); chk("R1 samples after reset", r, 32'd1024);
    rd32(5'h00, r); chk("R1 fifo cleared", r, 32'h0);
    // step counter back at 0: this commit loads ae lo = 2
    wr16(5'h0C, 16'h0200);
    wr16(5'h0E, 16'h0);
    push(1'b0, 30'h1); push(1'b0, 30'h2);
    rd32(5'h0A, r); chk("R1 step reset, ae at 2", r, csr_exp(2, 2, 0, 2'b11));
    push(1'b0, 30'h3);
    rd32(5'h0A, r); chk("R8 ae at 3", r, csr_exp(3, 2, 0, 2'b11));
    wr16(5'h0A, 16'h0000);
    wr16(5'h10, 16'h0000);                 // reset by write access
    chk("R12 write reset mode", 32'(acq_mode), 32'h0);
    rd32(5'h0A, r); chk("R12 status after write reset", r, csr_exp(0, 0, 0, 2'b11));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    push_valid = 1'b0; push_hdr = 1'b0; push_data = '0;
    acc_count = 12'hABC; rej_count = 12'h5A5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_program();
    t_flags_and_order();
    t_empty_read();
    t_full();
    t_misc_regs();
    t_soft_reset();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule